// File: doc/BRIEF.md
# Multi-Ratio Clock Enable Divider Bank

The block turns one reference clock into a family of phase-related clock enables. One enable runs at the full reference rate. A bank of fixed dividers runs at one half, one third, one quarter and one sixth of that rate. Two outputs have programmable ratios. The second programmable output also has a companion enable at half its rate, for logic that moves one data item per two of its clocks. Every output is a single-cycle pulse in the reference clock domain. Downstream logic uses each pulse as a clock enable rather than as a separate clock.

Software presents a new ratio for each programmable output on the ratio inputs and pulses a go strobe. The block captures both requests at the strobe. It forces each request into that output's legal range and records whether forcing was needed. A busy flag is then raised. The captured ratios are switched in only on the first cycle in which every divider counter sits at zero together. Because of this, all outputs restart in phase and no output emits a truncated period. Busy drops once the new ratios are running.

Top module: `clk_div_bank`

## Requirements
- R1: While rst_n is low at a clock edge, every enable output, busy_o, clamp_a_o and clamp_b_o read 0 after that edge. After reset the programmable ratios are 10 for output A and 6 for output B.
- R2: en_full_o is 1 in every cycle from the first cycle after rst_n is released.
- R3: The fixed enables en_fix_o[0], [1], [2] and [3] pulse once every 2, 3, 4 and 6 cycles respectively. All of them pulse in the first cycle after reset release.
- R4: en_a_o pulses once every active ratio A cycles. Its first pulse is in the first cycle after reset release or in the switch cycle.
- R5: en_b_o pulses once every active ratio B cycles, with the same starting points as R4.
- R6: en_b_half_o pulses only together with en_b_o, on every second en_b_o pulse. The first of these is the first en_b_o pulse after reset or after a switch, so its period is twice ratio B.
- R7: A go with ratio_a_i below 6 requests 6, and one above 32 requests 32. clamp_a_o is 1 in the cycle after a go whose ratio_a_i was out of range, and 0 after a go whose value was in range.
- R8: A go with ratio_b_i of 0 requests 1, and one above 32 requests 32. clamp_b_o follows the same rule as R7 over the range 1 to 32.
- R9: Without a go, changes on ratio_a_i and ratio_b_i alter no enable pattern and neither clamp flag.
- R10: busy_o is 1 from the cycle after a go through the switch cycle, and 0 in the cycle after the switch.
- R11: The switch cycle is the first cycle after the go in which every enable output is 1. The new ratios govern the periods that begin at that cycle.
- R12: A go issued while busy_o is 1 replaces the pending request. Only the latest request is applied, at a single switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go_i | input | 1 | Capture the ratio inputs and request a switch |
| ratio_a_i | input | RW (6) | Requested ratio for programmable output A |
| ratio_b_i | input | RW (6) | Requested ratio for programmable output B |
| en_full_o | output | 1 | Full-rate enable |
| en_fix_o | output | NFIX (4) | Fixed-ratio enables: /2, /3, /4, /6 |
| en_a_o | output | 1 | Programmable enable A |
| en_b_o | output | 1 | Programmable enable B |
| en_b_half_o | output | 1 | Enable at half the rate of en_b_o |
| busy_o | output | 1 | A requested switch is waiting for alignment |
| clamp_a_o | output | 1 | Last request for A was outside its range |
| clamp_b_o | output | 1 | Last request for B was outside its range |

## Verification
The assertions check the following on every cycle:
- the full-rate enable stays high and the outputs stay quiet before it comes up;
- the divide-by-two enable alternates, and the divide-by-six pulses coincide with the /2 and /3 pulses;
- the half-rate B enable never pulses without en_b_o;
- a go always raises busy, and busy only falls right after a cycle with every enable high;
- the clamp flags follow the range of the captured request and hold between strobes.

Only the bench's sweeps can show the exact period of each programmable output for every requested value. The same holds for the clamped value actually applied, for inputs without a strobe being ignored, and for a second strobe overriding the first.

// File: rtl/cdb_pkg.sv
// Package: shared constants and the range-fitting function of the divider bank.
// Assumes ratios are unsigned and at most 2**RATIO_W - 1.
package cdb_pkg;
    localparam int RATIO_W = 6;
    localparam int A_LO    = 6;
    localparam int A_HI    = 32;
    localparam int A_RST   = 10;
    localparam int B_LO    = 1;
    localparam int B_HI    = 32;
    localparam int B_RST   = 6;

    // Force a requested ratio into [lo, hi].
    function automatic int ratio_fit(input int v, input int lo, input int hi);
        if (v < lo)      return lo;
        else if (v > hi) return hi;
        else             return v;
    endfunction
endpackage

// File: rtl/cdb_counter.sv
// Module: one divider counter.
// It counts 0 .. ratio-1 while adv is high and flags the zero state.
// Assumes ratio >= 1. A ratio that shrinks below the count wraps at once.
module cdb_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic [W-1:0] ratio,
    output logic         at_zero
);
    logic [W-1:0] cnt;
    logic [W-1:0] last;

    // Terminal count for the ratio in force this cycle.
    always_comb last = ratio - W'(1);

    // Advance and wrap the count.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (adv) begin
            if (cnt >= last)  cnt <= '0;
            else              cnt <= cnt + W'(1);
        end
    end

    // Zero flag used both as the enable and for alignment.
    always_comb at_zero = (cnt == '0);
endmodule

// File: rtl/cdb_ratio_ctl.sv
// Module: the staging register for one programmable ratio.
// It captures a range-fitted request at go and moves it to the active ratio at load.
// eff presents the staged value during the load cycle, so the period that
// starts there already uses it.
// Assumes go and load are never high together (the top gates load with go).
module cdb_ratio_ctl
    import cdb_pkg::*;
#(
    parameter int W   = 6,
    parameter int LO  = 1,
    parameter int HI  = 32,
    parameter int RST = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic         load,
    input  logic [W-1:0] req,
    output logic [W-1:0] eff,
    output logic         clamped
);
    logic [W-1:0] staged;
    logic [W-1:0] active;
    logic [W-1:0] req_fit;
    logic         req_out;

    // Fit the request into range and note whether fitting changed it.
    always_comb begin
        req_fit = W'(ratio_fit(int'(req), LO, HI));
        req_out = (req_fit != req);
    end

    // Capture the request and its clamp flag on go.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged  <= W'(RST);
            clamped <= 1'b0;
        end else if (go) begin
            staged  <= req_fit;
            clamped <= req_out;
        end
    end

    // Promote the staged ratio at the alignment point.
    always_ff @(posedge clk) begin
        if (!rst_n)    active <= W'(RST);
        else if (load) active <= staged;
    end

    // Ratio seen by the counter this cycle.
    always_comb eff = load ? staged : active;
endmodule

// File: rtl/clk_div_bank.sv
// Module: top of the divider bank.
// It drives one full-rate enable, NFIX fixed-ratio enables, two programmable
// enables and a half-rate companion of the second one.
// All counters share one reset and one start cycle. Requested ratios switch in
// only when every counter is at zero in the same cycle.
// Assumes fixed ratios >= 1 and that each range fits in RW bits.
module clk_div_bank
    import cdb_pkg::*;
#(
    parameter int RW                = RATIO_W,
    parameter int NFIX              = 4,
    parameter int FIX_RATIO [NFIX]  = '{2, 3, 4, 6},
    parameter int A_MIN             = A_LO,
    parameter int A_MAX             = A_HI,
    parameter int A_DEF             = A_RST,
    parameter int B_MIN             = B_LO,
    parameter int B_MAX             = B_HI,
    parameter int B_DEF             = B_RST
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go_i,
    input  logic [RW-1:0]   ratio_a_i,
    input  logic [RW-1:0]   ratio_b_i,
    output logic            en_full_o,
    output logic [NFIX-1:0] en_fix_o,
    output logic            en_a_o,
    output logic            en_b_o,
    output logic            en_b_half_o,
    output logic            busy_o,
    output logic            clamp_a_o,
    output logic            clamp_b_o
);
    localparam logic [RW-1:0] HALF_RATIO = RW'(2);

    logic            live;
    logic            pending;
    logic            load;
    logic            all_zero;
    logic [NFIX-1:0] fix_zero;
    logic            a_zero;
    logic            b_zero;
    logic            h_zero;
    logic [RW-1:0]   a_eff;
    logic [RW-1:0]   b_eff;

    // Counters start one cycle after reset release, all together.
    always_ff @(posedge clk) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    // Fixed-ratio dividers, one per entry of FIX_RATIO.
    for (genvar i = 0; i < NFIX; i++) begin : g_fix
        cdb_counter #(.W(RW)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .adv     (live),
            .ratio   (RW'(FIX_RATIO[i])),
            .at_zero (fix_zero[i])
        );
    end

    // Ratio staging for programmable output A.
    cdb_ratio_ctl #(.W(RW), .LO(A_MIN), .HI(A_MAX), .RST(A_DEF)) u_ctl_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go_i),
        .load    (load),
        .req     (ratio_a_i),
        .eff     (a_eff),
        .clamped (clamp_a_o)
    );

    // Ratio staging for programmable output B.
    cdb_ratio_ctl #(.W(RW), .LO(B_MIN), .HI(B_MAX), .RST(B_DEF)) u_ctl_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go_i),
        .load    (load),
        .req     (ratio_b_i),
        .eff     (b_eff),
        .clamped (clamp_b_o)
    );

    // Programmable divider A.
    cdb_counter #(.W(RW)) u_cnt_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (live),
        .ratio   (a_eff),
        .at_zero (a_zero)
    );

    // Programmable divider B.
    cdb_counter #(.W(RW)) u_cnt_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (live),
        .ratio   (b_eff),
        .at_zero (b_zero)
    );

    // Divide-by-two of B, advanced on each B pulse.
    cdb_counter #(.W(RW)) u_cnt_h (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (live & b_zero),
        .ratio   (HALF_RATIO),
        .at_zero (h_zero)
    );

    // Alignment point: every counter at zero in a running cycle.
    always_comb all_zero = live & (&fix_zero) & a_zero & b_zero & h_zero;

    // A new go takes priority over loading an older request.
    always_comb load = pending & all_zero & ~go_i;

    // Hold a request until it is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= 1'b0;
        else        pending <= go_i | (pending & ~all_zero);
    end

    // Output enables, quiet until counting starts.
    always_comb begin
        en_full_o   = live;
        en_fix_o    = {NFIX{live}} & fix_zero;
        en_a_o      = live & a_zero;
        en_b_o      = live & b_zero;
        en_b_half_o = live & b_zero & h_zero;
        busy_o      = pending;
    end
endmodule

// File: rtl/cdb_checker.sv
// Module: property checker for clk_div_bank, attached with bind.
// Assumes the default fixed-ratio order (/2, /3, /4, /6) in en_fix_o.
module cdb_checker #(
    parameter int RW    = 6,
    parameter int NFIX  = 4,
    parameter int A_MIN = 6,
    parameter int A_MAX = 32,
    parameter int B_MIN = 1,
    parameter int B_MAX = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            go_i,
    input logic [RW-1:0]   ratio_a_i,
    input logic [RW-1:0]   ratio_b_i,
    input logic            en_full_o,
    input logic [NFIX-1:0] en_fix_o,
    input logic            en_a_o,
    input logic            en_b_o,
    input logic            en_b_half_o,
    input logic            busy_o,
    input logic            clamp_a_o,
    input logic            clamp_b_o
);
    logic all_en;
    logic a_out;
    logic b_out;

    // Helper terms over the ports.
    always_comb begin
        all_en = en_full_o & (&en_fix_o) & en_a_o & en_b_o & en_b_half_o;
        a_out  = (ratio_a_i < RW'(A_MIN)) || (ratio_a_i > RW'(A_MAX));
        b_out  = (ratio_b_i < RW'(B_MIN)) || (ratio_b_i > RW'(B_MAX));
    end

    p_quiet_before_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_full_o |-> (en_fix_o == '0 && !en_a_o && !en_b_o && !en_b_half_o));

    p_full_rate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> en_full_o);

    p_div2_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en_fix_o[0] |=> !en_fix_o[0]);

    p_div2_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_full_o && !en_fix_o[0]) |=> en_fix_o[0]);

    p_div6_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en_fix_o[3] |-> (en_fix_o[0] && en_fix_o[1]));

    p_half_subset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en_b_half_o |-> en_b_o);

    p_clamp_a_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && a_out) |=> clamp_a_o);

    p_clamp_a_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && !a_out) |=> !clamp_a_o);

    p_clamp_b_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && b_out) |=> clamp_b_o);

    p_clamp_b_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && !b_out) |=> !clamp_b_o);

    p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !go_i |=> $stable({clamp_a_o, clamp_b_o}));

    p_go_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |=> busy_o);

    p_switch_aligned_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(all_en));
endmodule

bind clk_div_bank cdb_checker #(
    .RW(RW), .NFIX(NFIX), .A_MIN(A_MIN), .A_MAX(A_MAX), .B_MIN(B_MIN), .B_MAX(B_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .go_i(go_i), .ratio_a_i(ratio_a_i), .ratio_b_i(ratio_b_i),
    .en_full_o(en_full_o), .en_fix_o(en_fix_o), .en_a_o(en_a_o), .en_b_o(en_b_o),
    .en_b_half_o(en_b_half_o), .busy_o(busy_o), .clamp_a_o(clamp_a_o), .clamp_b_o(clamp_b_o)
);

// File: tb/tb_clk_div_bank.sv
// Bench: sweeps every requested ratio 0..40 for both programmable outputs.
// Expected enable patterns are computed arithmetically from cycle indices.
module tb_clk_div_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go_i = 1'b0;
    logic [5:0] ratio_a_i = '0;
    logic [5:0] ratio_b_i = '0;
    logic       en_full_o, en_a_o, en_b_o, en_b_half_o, busy_o, clamp_a_o, clamp_b_o;
    logic [3:0] en_fix_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int fr [4] = '{2, 3, 4, 6};

    clk_div_bank dut (
        .clk(clk), .rst_n(rst_n), .go_i(go_i), .ratio_a_i(ratio_a_i), .ratio_b_i(ratio_b_i),
        .en_full_o(en_full_o), .en_fix_o(en_fix_o), .en_a_o(en_a_o), .en_b_o(en_b_o),
        .en_b_half_o(en_b_half_o), .busy_o(busy_o), .clamp_a_o(clamp_a_o), .clamp_b_o(clamp_b_o)
    );

    always #2 clk = ~clk;

    function automatic int fit(input int v, input int lo, input int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Compare every enable against index arithmetic for len cycles starting at index k0.
    task automatic measure(input int ea, input int eb, input int k0, input int len, input string tag);
        int bad_full = -1, bad_fix = -1, bad_a = -1, bad_b = -1, bad_h = -1, bad_busy = -1;
        for (int i = 0; i < len; i++) begin
            int k;
            if (i > 0 || k0 > 0) @(negedge clk);
            k = k0 + i;
            if (en_full_o !== 1'b1 && bad_full < 0) bad_full = k;
            for (int j = 0; j < 4; j++)
                if (en_fix_o[j] !== ((k % fr[j]) == 0) && bad_fix < 0) bad_fix = k;
            if (en_a_o !== ((k % ea) == 0) && bad_a < 0) bad_a = k;
            if (en_b_o !== ((k % eb) == 0) && bad_b < 0) bad_b = k;
            if (en_b_half_o !== ((k % (2 * eb)) == 0) && bad_h < 0) bad_h = k;
            if (k > 0 && busy_o !== 1'b0 && bad_busy < 0) bad_busy = k;
        end
        chk(bad_full < 0, {"R2 full rate ", tag}, bad_full, -1);
        chk(bad_fix < 0, {"R3 fixed ratios ", tag}, bad_fix, -1);
        chk(bad_a < 0, {"R4 period A ", tag}, bad_a, ea);
        chk(bad_b < 0, {"R5 period B ", tag}, bad_b, eb);
        chk(bad_h < 0, {"R6 half B ", tag}, bad_h, 2 * eb);
        chk(bad_busy < 0, {"R10 busy low after switch ", tag}, bad_busy, -1);
    endtask

    // Issue a go; check busy and clamp flags one cycle later.
    task automatic request(input int a, input int b);
        ratio_a_i = 6'(a);
        ratio_b_i = 6'(b);
        go_i = 1'b1;
        @(negedge clk);
        go_i = 1'b0;
        chk(busy_o === 1'b1, "R10 busy after go", busy_o, 1);
        chk(clamp_a_o === (a < 6 || a > 32), "R7 clamp A flag", clamp_a_o, (a < 6 || a > 32));
        chk(clamp_b_o === (b < 1 || b > 32), "R8 clamp B flag", clamp_b_o, (b < 1 || b > 32));
    endtask

    // Wait for the switch cycle, then check the new pattern from it.
    task automatic settle(input int ea, input int eb, input int len);
        int waited = 0;
        bit early = 0;
        while (!(en_full_o && (&en_fix_o) && en_a_o && en_b_o && en_b_half_o) && waited < 20000) begin
            if (busy_o !== 1'b1) early = 1;
            @(negedge clk);
            waited++;
        end
        chk(!early, "R10 busy held until switch", early, 0);
        chk(busy_o === 1'b1 && waited < 20000, "R11 aligned switch reached", waited, 0);
        measure(ea, eb, 0, len, "after switch");
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int win;
        repeat (3) @(negedge clk);
        chk({en_full_o, en_fix_o, en_a_o, en_b_o, en_b_half_o, busy_o, clamp_a_o, clamp_b_o} == '0,
            "R1 reset state", {en_full_o, en_fix_o, en_a_o, en_b_o, en_b_half_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        measure(10, 6, 0, 120, "R1 defaults");

        // Sweep A over 0..40 with B at 1.
        for (int a = 0; a <= 40; a++) begin
            request(a, 1);
            settle(fit(a, 6, 32), 1, 70);
        end
        // Sweep B over 0..40 with A at 6.
        for (int b = 0; b <= 40; b++) begin
            win = 2 * fit(b, 1, 32) * 2 + 12;
            request(6, b);
            settle(6, fit(b, 1, 32), win);
        end
        // R9: ratio inputs move without go; pattern and flags hold.
        ratio_a_i = 6'd20;
        ratio_b_i = 6'd3;
        measure(6, 32, 140, 200, "R9 inputs ignored");
        chk(clamp_b_o === 1'b1 && clamp_a_o === 1'b0, "R9 flags hold", {clamp_a_o, clamp_b_o}, 1);

        // R12: a second go while busy replaces the first request.
        ratio_a_i = 6'd20;
        ratio_b_i = 6'd20;
        go_i = 1'b1;
        @(negedge clk);
        ratio_a_i = 6'd7;
        ratio_b_i = 6'd3;
        @(negedge clk);
        go_i = 1'b0;
        chk(busy_o === 1'b1, "R12 busy after second go", busy_o, 1);
        settle(7, 3, 100);

        // Mixed values, then reset mid-run.
        request(9, 5);
        settle(9, 5, 80);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk({en_full_o, en_fix_o, en_a_o, en_b_o, en_b_half_o, busy_o, clamp_a_o, clamp_b_o} == '0,
            "R1 reset mid-run", en_full_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        measure(10, 6, 0, 120, "R1 defaults after reset");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule